// File: doc/BRIEF.md
# Wake-up frame data matcher

This block decides whether the data field of a received classical CAN frame qualifies as a wake-up frame. An upstream frame decoder marks the start of each frame and supplies its length code. It then streams the data bytes with a valid strobe, and closes the frame with either an end strobe or an abort strobe. The block compares the streamed bytes against eight configured pattern bytes and reports the outcome with a one-cycle result pulse and a held match flag.

The comparison runs from the back of the frame. The final data byte always lines up with pattern byte 0, and each earlier byte lines up with the next higher pattern index, whatever the frame length. A frame qualifies as soon as any single 1 bit in a data byte falls on a 1 bit of its pattern byte. This is a reduction OR over bitwise ANDs, not an equality compare. A small write port loads the pattern bytes and a check-enable bit. Pattern and enable are copied into a shadow at frame start, so software may rewrite them at any time without disturbing a frame in flight.

Top module: `wuf_data_match`

## Requirements
- R1: Bit 0 written to address 0x38 is the check-enable. When the shadowed enable is 0, the result reports a match whatever the frame holds.
- R2: Address 0x39+i (i = 0..7) loads pattern byte i. A write to any other address, such as 0x37 or 0x41, leaves pattern and enable unchanged.
- R3: With the check enabled, a frame matches exactly when some data byte ANDed with its mapped pattern byte is nonzero.
- R4: For a frame of n data bytes, the k-th byte received (k from 0) maps to pattern byte n-1-k. With n=8 the first byte maps to byte 7; with n=3 the first maps to byte 2 and the last to byte 0.
- R5: Pattern bytes at index n or above take no part, and bytes streamed beyond n are ignored. With the check enabled, n=0 gives no match.
- R6: Length codes 9 to 15 are treated as 8 data bytes.
- R7: The result pulse is high for exactly one cycle, in the cycle after the end strobe is sampled. The match flag changes only together with that pulse and holds its value otherwise.
- R8: An abort strobe discards the frame in progress and no result pulse follows. An end strobe with no frame in progress is ignored.
- R9: A pattern or enable write made while a frame is in progress affects only frames that start afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 8 | Register write address |
| cfg_wdata_i | input | 8 | Register write data |
| frm_start_i | input | 1 | Frame start strobe |
| frm_dlc_i | input | 4 | Length code, sampled with the start strobe |
| byte_valid_i | input | 1 | Data byte strobe |
| byte_i | input | 8 | Data byte |
| frm_end_i | input | 1 | Frame end strobe |
| frm_abort_i | input | 1 | Error or abort strobe |
| res_valid_o | output | 1 | One-cycle result pulse |
| match_o | output | 1 | Match flag, updated with the result pulse |

## Verification
A single set bit is placed at the first byte, at the last byte and at mirror positions. This separates reverse mapping from forward mapping for full-length and short frames. Patterns that fill only the unused high indices, extra bytes streamed past the length, a zero length and an oversized length code each test the length handling on its own. Paired patterns with disjoint bits and with one shared bit tell the overlap test apart from an equality test. Directed sequences cover aborts, stray end strobes, writes to neighbouring addresses and mid-frame rewrites of the pattern.

// File: rtl/wuf_pkg.sv
package wuf_pkg;
  localparam int WUF_NB    = 8;
  localparam int WUF_BW    = 8;
  localparam int WUF_AW    = 8;
  localparam int WUF_DLC_W = 4;
endpackage

// File: rtl/wuf_cfg_regs.sv
module wuf_cfg_regs #(
  parameter int NB        = 8,
  parameter int BW        = 8,
  parameter int AW        = 8,
  parameter int CTRL_ADDR = 'h38,
  parameter int PAT_BASE  = 'h39
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [BW-1:0]    wdata_i,
  output logic [NB*BW-1:0] pat_o,
  output logic             en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   en_o <= 1'b0;
    else if (we_i && addr_i == AW'(CTRL_ADDR))     en_o <= wdata_i[0];
  end

  for (genvar i = 0; i < NB; i++) begin : g_pat
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 pat_o[i*BW +: BW] <= '0;
      else if (we_i && addr_i == AW'(PAT_BASE + i)) pat_o[i*BW +: BW] <= wdata_i;
    end
  end
endmodule

// File: rtl/wuf_frame_track.sv
module wuf_frame_track #(
  parameter int NB    = 8,
  parameter int DLC_W = 4,
  localparam int CNT_W = $clog2(NB + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DLC_W-1:0] dlc_i,
  input  logic             byte_valid_i,
  input  logic             end_i,
  input  logic             abort_i,
  output logic             in_frame_o,
  output logic             take_o,
  output logic [CNT_W-1:0] idx_o,
  output logic             fin_o
);
  logic [CNT_W-1:0] n_q, cnt_q, eff_n;

  // length codes above NB saturate
  assign eff_n = (dlc_i > DLC_W'(NB)) ? CNT_W'(NB) : CNT_W'(dlc_i);

  assign take_o = in_frame_o && byte_valid_i && !start_i && !abort_i && !end_i
                  && (cnt_q < n_q);
  assign fin_o  = in_frame_o && end_i && !start_i && !abort_i;
  // reverse mapping: last byte lands on index 0
  assign idx_o  = n_q - cnt_q - CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_o <= 1'b0;
      n_q        <= '0;
      cnt_q      <= '0;
    end else if (start_i) begin
      in_frame_o <= 1'b1;
      n_q        <= eff_n;
      cnt_q      <= '0;
    end else if (abort_i || fin_o) begin
      in_frame_o <= 1'b0;
    end else if (take_o) begin
      cnt_q      <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/wuf_hit_acc.sv
module wuf_hit_acc #(
  parameter int NB = 8,
  parameter int BW = 8,
  localparam int CNT_W = $clog2(NB + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NB*BW-1:0] pat_i,
  input  logic             en_i,
  input  logic             take_i,
  input  logic [CNT_W-1:0] idx_i,
  input  logic [BW-1:0]    byte_i,
  input  logic             fin_i,
  input  logic             abort_i,
  output logic             en_sh_o,
  output logic             res_valid_o,
  output logic             match_o
);
  logic [NB*BW-1:0] pat_sh_q;
  logic             hit_q;
  logic [BW-1:0]    sel_pat;

  assign sel_pat = pat_sh_q[idx_i*BW +: BW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pat_sh_q <= '0;
      en_sh_o  <= 1'b0;
      hit_q    <= 1'b0;
    end else if (start_i) begin
      pat_sh_q <= pat_i;
      en_sh_o  <= en_i;
      hit_q    <= 1'b0;
    end else if (abort_i) begin
      hit_q    <= 1'b0;
    end else if (take_i) begin
      hit_q    <= hit_q | (|(byte_i & sel_pat));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      match_o     <= 1'b0;
    end else begin
      res_valid_o <= fin_i;
      if (fin_i) match_o <= !en_sh_o || hit_q;
    end
  end
endmodule

// File: rtl/wuf_data_match.sv
module wuf_data_match
  import wuf_pkg::*;
#(
  parameter int NB        = WUF_NB,
  parameter int BW        = WUF_BW,
  parameter int AW        = WUF_AW,
  parameter int DLC_W     = WUF_DLC_W,
  parameter int CTRL_ADDR = 'h38,
  parameter int PAT_BASE  = 'h39
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [AW-1:0]    cfg_addr_i,
  input  logic [BW-1:0]    cfg_wdata_i,
  input  logic             frm_start_i,
  input  logic [DLC_W-1:0] frm_dlc_i,
  input  logic             byte_valid_i,
  input  logic [BW-1:0]    byte_i,
  input  logic             frm_end_i,
  input  logic             frm_abort_i,
  output logic             res_valid_o,
  output logic             match_o
);
  localparam int CNT_W = $clog2(NB + 1);

  logic [NB*BW-1:0] pat_live;
  logic             en_live, en_sh, in_frame, take, fin;
  logic [CNT_W-1:0] idx;

  wuf_cfg_regs #(.NB(NB), .BW(BW), .AW(AW), .CTRL_ADDR(CTRL_ADDR), .PAT_BASE(PAT_BASE)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
    .wdata_i(cfg_wdata_i), .pat_o(pat_live), .en_o(en_live)
  );

  wuf_frame_track #(.NB(NB), .DLC_W(DLC_W)) u_track (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(frm_start_i), .dlc_i(frm_dlc_i),
    .byte_valid_i(byte_valid_i), .end_i(frm_end_i), .abort_i(frm_abort_i),
    .in_frame_o(in_frame), .take_o(take), .idx_o(idx), .fin_o(fin)
  );

  wuf_hit_acc #(.NB(NB), .BW(BW)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(frm_start_i), .pat_i(pat_live),
    .en_i(en_live), .take_i(take), .idx_i(idx), .byte_i(byte_i), .fin_i(fin),
    .abort_i(frm_abort_i), .en_sh_o(en_sh), .res_valid_o(res_valid_o), .match_o(match_o)
  );
endmodule

// File: rtl/wuf_data_match_chk.sv
module wuf_data_match_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic frm_start_i,
  input logic frm_end_i,
  input logic frm_abort_i,
  input logic in_frame_i,
  input logic en_sh_i,
  input logic res_valid_o,
  input logic match_o
);
  p_res_after_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> ($past(frm_end_i) && $past(in_frame_i)));
  p_pulse_once_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);
  p_match_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_o |-> $stable(match_o));
  p_disabled_match_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !$past(en_sh_i)) |-> match_o);
  p_abort_silent_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_abort_i |=> !res_valid_o);
  p_stray_end_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_end_i && !in_frame_i && !frm_start_i) |=> !res_valid_o);
  p_start_opens_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_start_i |=> in_frame_i);
endmodule

bind wuf_data_match wuf_data_match_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .frm_start_i(frm_start_i), .frm_end_i(frm_end_i),
  .frm_abort_i(frm_abort_i), .in_frame_i(in_frame), .en_sh_i(en_sh),
  .res_valid_o(res_valid_o), .match_o(match_o)
);

// File: tb/sim_wuf_data_match.sv
module sim_wuf_data_match;
  logic       clk = 0, rst_n = 0;
  logic       cfg_we = 0, frm_start = 0, byte_valid = 0, frm_end = 0, frm_abort = 0;
  logic [7:0] cfg_addr = 0, cfg_wdata = 0, byte_d = 0;
  logic [3:0] frm_dlc = 0;
  logic       res_valid, match;
  int total = 0, bad = 0;
  bit done = 0;

  always #5ns clk = ~clk;

  wuf_data_match u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .frm_start_i(frm_start), .frm_dlc_i(frm_dlc),
    .byte_valid_i(byte_valid), .byte_i(byte_d), .frm_end_i(frm_end),
    .frm_abort_i(frm_abort), .res_valid_o(res_valid), .match_o(match)
  );

  // pat: index i at [8i+:8]; dat: k-th byte sent at [8k+:8]
  typedef struct packed {
    logic        en;
    logic [3:0]  dlc;
    logic [3:0]  nb;
    logic [63:0] pat;
    logic [63:0] dat;
    logic        exp;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{1'b1, 4'd8,  4'd8, 64'h0100_0000_0000_0000, 64'h0000_0000_0000_0001, 1'b1}, // R4 first->7
    '{1'b1, 4'd8,  4'd8, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001, 1'b0}, // R4 not forward
    '{1'b1, 4'd3,  4'd3, 64'h0000_0000_0080_0000, 64'h0000_0000_0000_0080, 1'b1}, // R4 dlc3 first->2
    '{1'b1, 4'd3,  4'd3, 64'h0000_0000_0000_0080, 64'h0000_0000_0000_0080, 1'b0}, // R4
    '{1'b1, 4'd3,  4'd3, 64'h0000_0000_0000_0010, 64'h0000_0000_0010_0000, 1'b1}, // R4 last->0
    '{1'b1, 4'd3,  4'd3, 64'hFFFF_FFFF_FF00_0000, 64'h0000_0000_00FF_FFFF, 1'b0}, // R5 high idx
    '{1'b1, 4'd0,  4'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0,                   1'b0}, // R5 dlc0
    '{1'b0, 4'd2,  4'd2, 64'h0,                   64'h0,                   1'b1}, // R1 disabled
    '{1'b1, 4'd12, 4'd8, 64'h0200_0000_0000_0000, 64'h0000_0000_0000_0002, 1'b1}, // R6 clamp
    '{1'b1, 4'd4,  4'd4, 64'h0000_0000_0000_0F00, 64'h0000_0000_00F0_0000, 1'b0}, // R3 disjoint
    '{1'b1, 4'd4,  4'd4, 64'h0000_0000_0000_0F00, 64'h0000_0000_0018_0000, 1'b1}, // R3 one bit
    '{1'b1, 4'd2,  4'd3, 64'h0000_0000_0000_0001, 64'h0000_0000_0001_0000, 1'b0}  // R5 extra byte
  };

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic load_cfg(input logic en, input logic [63:0] pat);
    cfg_write(8'h38, {7'd0, en});
    for (int i = 0; i < 8; i++) cfg_write(8'h39 + 8'(i), pat[8*i +: 8]);
  endtask

  task automatic send_bytes(input int nb, input logic [63:0] dat);
    for (int k = 0; k < nb; k++) begin
      byte_valid = 1; byte_d = dat[8*k +: 8];
      @(negedge clk);
    end
    byte_valid = 0;
  endtask

  // returns at the negedge after the end strobe was sampled
  task automatic run_frame(input logic [3:0] dlc, input int nb, input logic [63:0] dat);
    @(negedge clk); frm_start = 1; frm_dlc = dlc;
    @(negedge clk); frm_start = 0;
    send_bytes(nb, dat);
    frm_end = 1;
    @(negedge clk); frm_end = 0;
  endtask

  initial begin
    #2ms;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog R7 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R7 reset valid", res_valid, 1'b0);
    chk("R7 reset match", match, 1'b0);
    rst_n = 1;

    foreach (VECS[v]) begin
      load_cfg(VECS[v].en, VECS[v].pat);
      run_frame(VECS[v].dlc, int'(VECS[v].nb), VECS[v].dat);
      chk($sformatf("R7 valid vec%0d", v), res_valid, 1'b1);
      chk($sformatf("R3/R4/R5 match vec%0d", v), match, VECS[v].exp);
      @(negedge clk);
      chk($sformatf("R7 pulse width vec%0d", v), res_valid, 1'b0);
    end

    // R7 hold between results (last vector gave 0)
    repeat (4) @(negedge clk);
    chk("R7 hold", match, 1'b0);

    // R2 writes to neighbouring addresses ignored
    load_cfg(1'b1, 64'h0);
    cfg_write(8'h37, 8'hFF);
    cfg_write(8'h41, 8'hFF);
    run_frame(4'd8, 8, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R2 stray addr", match, 1'b0);

    // R1 only bit 0 of control counts
    cfg_write(8'h38, 8'hFE);
    run_frame(4'd1, 1, 64'h0);
    chk("R1 disable via bit0", match, 1'b1);

    // R8 abort discards frame
    load_cfg(1'b1, 64'hFF);
    run_frame(4'd1, 1, 64'h00);
    chk("R8 setup", match, 1'b0);
    @(negedge clk); frm_start = 1; frm_dlc = 4'd1;
    @(negedge clk); frm_start = 0;
    send_bytes(1, 64'hFF);
    frm_abort = 1;
    @(negedge clk); frm_abort = 0;
    chk("R8 abort no pulse", res_valid, 1'b0);
    @(negedge clk);
    chk("R8 abort match kept", match, 1'b0);
    frm_end = 1;
    @(negedge clk); frm_end = 0;
    chk("R8 stray end no pulse", res_valid, 1'b0);
    chk("R8 stray end match", match, 1'b0);

    // R9 mid-frame pattern write deferred
    load_cfg(1'b1, 64'h0);
    @(negedge clk); frm_start = 1; frm_dlc = 4'd1;
    @(negedge clk); frm_start = 0;
    cfg_write(8'h39, 8'hFF);
    send_bytes(1, 64'hFF);
    frm_end = 1;
    @(negedge clk); frm_end = 0;
    chk("R9 deferred valid", res_valid, 1'b1);
    chk("R9 deferred match", match, 1'b0);
    run_frame(4'd1, 1, 64'hFF);
    chk("R9 next frame match", match, 1'b1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule